// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller

This block collects up to 64 active-low interrupt inputs and reduces them to one request line for a processor. Software reaches it through a small register bus. It has two mask words, two pending words, one word that picks the sensing mode, and a read-only vector word. The vector word reports the number of the winning source.

A fixed, non-arithmetic table ties each source number to a word and a bit. Most sources are internal and are always sensed as active-low levels. Seven external sources can each be switched between level sensing and falling-edge sensing. Sixteen port sources can each be switched between falling-edge-only and both-edge detection. Every input passes through a two-stage synchronizer before any detection. Priority is fixed: the lowest-numbered active source wins.

Top module: `irq_ctrl64`

## Requirements
- R1: After reset, both mask words read 0, both pending words read 0 while all inputs are high, the vector word reads 0 and `irq_out` is low.
- R2: Source s sits in the high word when 16<=s<=31 or s>=48, and in the low word otherwise. Its bit is 16-s for 1..15, 18-s for 16..18, 33-s for 19..30, 63-s for 32..47 and s-32 for 48..63.
- R3: A mask bit of 1 lets its source reach the output and the vector. A mask bit of 0 blocks it, but the pending bit still shows.
- R4: Writing 1 to a pending bit clears an edge-latched source. Writing 0 has no effect. A new edge in the same cycle wins over the clear.
- R5: For a level-sensed source, the pending bit follows the synchronized input. A write of 1 cannot clear it while the input stays low.
- R6: The vector word holds, in bits 31:26, the lowest-numbered source that is both pending and unmasked. It holds 0 when there is none. Bits 25:0 always read 0.
- R7: External sources 19..25 use edge-select bits 14..8, with bit = 33-s. Bit=1 latches on a falling edge. Bit=0 senses the low level.
- R8: Port sources 48..63 use edge-select bits 16..31, with bit = s-32. Bit=1 latches on falling edges only. Bit=0 latches on both edges.
- R9: `irq_out` is high exactly when some pending bit has its mask bit set.
- R10: Sources 0 and 31 are reserved. They never become pending, whatever their inputs do.
- R11: The register addresses are: 0 = high mask, 1 = low mask, 2 = high pending, 3 = low pending, 4 = edge select, 5 = vector. Addresses 6 and 7 read 0. The mask and edge-select words read back as written.
- R12: A level input that goes low shows up in its pending bit after exactly two clock edges. Edge detection adds one more edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_n | input | 64 | Active-low interrupt inputs, indexed by source number |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A wrong internal state shows up at the ports in the cycle after the faulty register updates:
- a misrouted source puts its pending bit in the wrong word or position;
- a stuck latch keeps `irq_out` high after the clearing write;
- a wrong priority comparison puts the wrong number in bits 31:26 of the vector word.

Sensing faults take longer to show. They appear two or three edges after an input change, because the synchronizer and the edge stage lie in between. The checks therefore sample the pending words at the exact edge count, and again after the input is released, so that a level source posing as an edge source (or the reverse) is caught.

// File: rtl/irq64_pkg.sv
// Shared constants, types and the fixed source-to-bit mapping of the
// 64-source interrupt controller. Assumes exactly 64 sources, 32-bit words.
package irq64_pkg;
    localparam int NSRC    = 64;
    localparam int DW      = 32;
    localparam int SIDX_W  = $clog2(NSRC);
    localparam int AW      = 3;
    localparam int VEC_LSB = DW - SIDX_W;

    typedef enum logic [1:0] {
        K_INTERNAL = 2'd0,
        K_EXTERNAL = 2'd1,
        K_PORT     = 2'd2,
        K_RESERVED = 2'd3
    } src_kind_e;

    typedef enum logic [AW-1:0] {
        A_MASK_HI = 3'd0,
        A_MASK_LO = 3'd1,
        A_PEND_HI = 3'd2,
        A_PEND_LO = 3'd3,
        A_EDGE    = 3'd4,
        A_VECTOR  = 3'd5
    } reg_addr_e;

    // Sensing class of a source number
    function automatic src_kind_e kind_of(input int s);
        if (s == 0 || s == 31)   return K_RESERVED;
        if (s >= 19 && s <= 25)  return K_EXTERNAL;
        if (s >= 48)             return K_PORT;
        return K_INTERNAL;
    endfunction

    // True when the source lives in the high word
    function automatic bit word_is_hi(input int s);
        return (s >= 16 && s <= 31) || (s >= 48);
    endfunction

    // Bit position of the source inside its word
    function automatic int bit_of(input int s);
        if (s == 0)  return 0;
        if (s <= 15) return 16 - s;
        if (s <= 18) return 18 - s;
        if (s <= 30) return 33 - s;
        if (s == 31) return 0;
        if (s <= 47) return 63 - s;
        return s - 32;
    endfunction

    // Edge-select bit used by a source (0 for sources without one)
    function automatic int edge_bit_of(input int s);
        if (s >= 19 && s <= 25) return 33 - s;
        if (s >= 48)            return s - 32;
        return 0;
    endfunction
endpackage

// File: rtl/irq64_src_cell.sv
// One interrupt source: synchronizer, edge detector and pending latch.
// Assumes src_n is asynchronous and active-low, SYNC_STAGES >= 2.
// The KIND parameter fixes the sensing class at elaboration.
module irq64_src_cell
    import irq64_pkg::*;
#(
    parameter src_kind_e KIND        = K_INTERNAL,
    parameter int        SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_n,
    input  logic edge_sel,
    input  logic clr,
    output logic pend
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   latch_q;
    logic                   last;
    logic                   fall;
    logic                   rise;
    logic                   is_edge;
    logic                   hit;

    assign last = sync_q[SYNC_STAGES-1];
    assign fall = prev_q & ~last;
    assign rise = ~prev_q & last;

    // Pick edge or level sensing from the class and the select bit
    always_comb begin
        is_edge = (KIND == K_PORT) || ((KIND == K_EXTERNAL) && edge_sel);
        if (KIND == K_PORT)
            hit = fall | (~edge_sel & rise);
        else
            hit = is_edge & fall;
    end

    // Synchronize the input and keep its previous synchronized value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], src_n};
            prev_q <= last;
        end
    end

    // Latch a detected edge; a new edge wins over a clearing write
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= 1'b0;
        else if (hit)
            latch_q <= 1'b1;
        else if (clr)
            latch_q <= 1'b0;
    end

    assign pend = is_edge ? latch_q : (~last & (KIND != K_RESERVED));
endmodule

// File: rtl/irq64_prio_enc.sv
// Fixed-priority encoder: returns the lowest index with a request set.
// Assumes index 0 is never requested, so idx==0 also means "none".
module irq64_prio_enc #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top so the lowest active index is assigned last
    always_comb begin
        idx = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = i[IW-1:0];
        end
    end
endmodule

// File: rtl/irq_ctrl64.sv
// Top of the 64-source interrupt controller. Holds the mask and
// edge-select words, routes sources through the fixed bit table, builds
// the pending words and the vector, and drives one request output.
// Assumes a single-cycle register bus with combinational read data.
module irq_ctrl64
    import irq64_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_n,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_out
);
    logic [DW-1:0]     mask_hi_q, mask_lo_q, edge_q;
    logic [DW-1:0]     pend_hi, pend_lo;
    logic [NSRC-1:0]   pend_src, mask_src, clr_src, act_src;
    logic [SIDX_W-1:0] vec_idx;
    logic              any_act;

    // Per-source cells with their mask, clear and edge-select routing
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam bit        HI = word_is_hi(s);
        localparam int        BP = bit_of(s);
        localparam int        EB = edge_bit_of(s);
        localparam reg_addr_e PA = HI ? A_PEND_HI : A_PEND_LO;

        assign mask_src[s] = HI ? mask_hi_q[BP] : mask_lo_q[BP];
        assign clr_src[s]  = bus_we && (bus_addr == PA) && bus_wdata[BP];

        irq64_src_cell #(
            .KIND        (kind_of(s)),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_n    (src_n[s]),
            .edge_sel (edge_q[EB]),
            .clr      (clr_src[s]),
            .pend     (pend_src[s])
        );
    end

    assign act_src = pend_src & mask_src;

    // Gather per-source pending bits into the two words through the table
    always_comb begin
        pend_hi = '0;
        pend_lo = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (word_is_hi(s)) pend_hi[bit_of(s)] = pend_hi[bit_of(s)] | pend_src[s];
            else               pend_lo[bit_of(s)] = pend_lo[bit_of(s)] | pend_src[s];
        end
    end

    irq64_prio_enc #(.N(NSRC), .IW(SIDX_W)) u_prio (
        .req (act_src),
        .idx (vec_idx),
        .any (any_act)
    );

    assign irq_out = any_act;

    // Software-written mask and edge-select words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_hi_q <= '0;
            mask_lo_q <= '0;
            edge_q    <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_MASK_HI: mask_hi_q <= bus_wdata;
                A_MASK_LO: mask_lo_q <= bus_wdata;
                A_EDGE:    edge_q    <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        case (bus_addr)
            A_MASK_HI: bus_rdata = mask_hi_q;
            A_MASK_LO: bus_rdata = mask_lo_q;
            A_PEND_HI: bus_rdata = pend_hi;
            A_PEND_LO: bus_rdata = pend_lo;
            A_EDGE:    bus_rdata = edge_q;
            A_VECTOR:  bus_rdata = {vec_idx, {VEC_LSB{1'b0}}};
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq64_checker.sv
// Property checker for irq_ctrl64, attached by bind. Observes ports and
// the per-source active vector and winner index.
module irq64_checker
    import irq64_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              irq_out,
    input logic [AW-1:0]     bus_addr,
    input logic [DW-1:0]     bus_rdata,
    input logic [DW-1:0]     mask_hi_q,
    input logic [DW-1:0]     mask_lo_q,
    input logic [NSRC-1:0]   act_src,
    input logic [SIDX_W-1:0] vec_idx
);
    AST_MASK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mask_hi_q == '0 && mask_lo_q == '0)); // R1
    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_hi_q == '0 && mask_lo_q == '0) |-> !irq_out); // R3
    AST_VEC_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_VECTOR) |-> (bus_rdata[VEC_LSB-1:0] == '0)); // R6
    AST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_idx != '0) |-> act_src[vec_idx]); // R6
    AST_IRQ_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (vec_idx != '0)); // R9
    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !act_src[0] && !act_src[31]); // R10
endmodule

bind irq_ctrl64 irq64_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_out   (irq_out),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .mask_hi_q (mask_hi_q),
    .mask_lo_q (mask_lo_q),
    .act_src   (act_src),
    .vec_idx   (vec_idx)
);

// File: tb/irq_ctrl64_test.sv
`timescale 1ns/1ps
module irq_ctrl64_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_n = '1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    localparam logic [2:0] MH = 3'd0, ML = 3'd1, PH = 3'd2, PL = 3'd3, ED = 3'd4, VC = 3'd5;

    always #4 clk = ~clk;

    irq_ctrl64 uut (
        .clk(clk), .rst_n(rst_n), .src_n(src_n), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    // Monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq_out} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        bus_addr = a;
        sb_q.push_back('{1'b0, e, t});
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(posedge clk); #1;
        sb_q.push_back('{1'b1, {31'b0, e}, t});
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic drive(input int idx, input logic v);
        @(posedge clk); #1;
        src_n[idx] = v;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk_reg(MH, 32'h0, "R1 mask_hi after reset");
        chk_reg(ML, 32'h0, "R1 mask_lo after reset");
        chk_reg(PH, 32'h0, "R1 pend_hi after reset");
        chk_reg(PL, 32'h0, "R1 pend_lo after reset");
        chk_reg(VC, 32'h0, "R1 vector after reset");
        chk_irq(1'b0, "R1 irq after reset");

        // R5/R3 internal source 5 -> low word bit 11, masked
        drive(5, 1'b0); settle();
        chk_reg(PL, 32'h0000_0800, "R2 R5 src5 pending low bit 11");
        chk_irq(1'b0, "R3 masked source keeps irq low");
        chk_reg(VC, 32'h0, "R3 masked source gives vector 0");
        wr(ML, 32'h0000_0800);
        chk_reg(ML, 32'h0000_0800, "R11 mask_lo readback");
        chk_irq(1'b1, "R9 unmasked pending raises irq");
        chk_reg(VC, 32'h1400_0000, "R6 vector holds 5");
        wr(PL, 32'hFFFF_FFFF);
        chk_reg(PL, 32'h0000_0800, "R5 clear write cannot clear held level");
        drive(5, 1'b1); settle();
        chk_reg(PL, 32'h0, "R5 level pending follows release");
        chk_irq(1'b0, "R9 irq drops with no active source");

        // R6 priority between 20 (high bit 13) and 40 (low bit 23)
        wr(MH, 32'h0000_2000);
        wr(ML, 32'h0080_0800);
        drive(40, 1'b0); drive(20, 1'b0); settle();
        chk_reg(VC, 32'h5000_0000, "R6 lowest number 20 wins over 40");
        drive(20, 1'b1); settle();
        chk_reg(VC, 32'hA000_0000, "R6 vector moves to 40");
        drive(40, 1'b1); settle();
        chk_reg(VC, 32'h0, "R6 vector 0 when idle");

        // R7 external 22: edge bit 11, high word bit 11
        wr(ED, 32'h0000_0800);
        chk_reg(ED, 32'h0000_0800, "R11 edge word readback");
        wr(MH, 32'h0000_2800);
        drive(22, 1'b0); settle();
        drive(22, 1'b1); settle();
        chk_reg(PH, 32'h0000_0800, "R7 falling edge latched after release");
        chk_reg(VC, 32'h5800_0000, "R7 vector holds 22");
        wr(PH, 32'h0000_0000);
        chk_reg(PH, 32'h0000_0800, "R4 zero write leaves latch set");
        wr(PH, 32'h0000_0800);
        chk_reg(PH, 32'h0, "R4 one write clears latch");
        chk_irq(1'b0, "R4 irq low after clear");

        // R8 port 50: high word bit 18, edge bit 18
        wr(ED, 32'h0);
        drive(50, 1'b0); settle();
        chk_reg(PH, 32'h0004_0000, "R8 both-edge mode catches fall");
        wr(PH, 32'h0004_0000);
        chk_reg(PH, 32'h0, "R4 port latch cleared");
        drive(50, 1'b1); settle();
        chk_reg(PH, 32'h0004_0000, "R8 both-edge mode catches rise");
        wr(PH, 32'h0004_0000);
        wr(ED, 32'h0004_0000);
        drive(50, 1'b0); settle();
        chk_reg(PH, 32'h0004_0000, "R8 fall-only mode catches fall");
        wr(PH, 32'h0004_0000);
        drive(50, 1'b1); settle();
        chk_reg(PH, 32'h0, "R8 fall-only mode ignores rise");

        // R10 reserved sources
        drive(0, 1'b0); drive(31, 1'b0); settle();
        chk_reg(PH, 32'h0, "R10 source 31 never pending");
        chk_reg(PL, 32'h0, "R10 source 0 never pending");
        chk_reg(VC, 32'h0, "R10 vector stays 0");
        drive(0, 1'b1); drive(31, 1'b1);

        // R2 mapping of several table rows
        drive(1, 1'b0); drive(33, 1'b0); drive(16, 1'b0); drive(30, 1'b0); settle();
        chk_reg(PL, 32'h4000_8000, "R2 sources 1 and 33 in low word");
        chk_reg(PH, 32'h0000_000C, "R2 sources 16 and 30 in high word");
        drive(1, 1'b1); drive(33, 1'b1); drive(16, 1'b1); drive(30, 1'b1); settle();

        // R12 latency of a level source: 7 -> low bit 9
        drive(7, 1'b0);
        chk_reg(PL, 32'h0, "R12 not visible after one edge");
        chk_reg(PL, 32'h0000_0200, "R12 visible after two edges");
        drive(7, 1'b1);
        chk_reg(3'd6, 32'h0, "R11 unused address reads 0");

        @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule